// File: doc/BRIEF.md
# Two-Level Local History Branch Predictor

This block guesses the direction of a conditional branch from the recent behaviour of that same branch. A branch address first selects an entry in a history table. Each entry is a short shift register that holds the last few taken/not-taken outcomes of the branches mapped to it. The history value read there then selects one of a set of 2-bit saturating counters. The upper bit of that counter is the prediction.

The front end places a branch address on the predict port. One cycle later it receives the prediction and the history value used to form it. It keeps that history with the branch. When the branch resolves, it returns the address, the same history value and the real outcome on the update port. The block then trains the counter picked by the returned history and shifts the outcome into that branch's history entry. Entries carry no tags, so branches whose index bits match share state.

Top module: `local_hist_predictor`

## Requirements
- R1: After reset every history entry is zero and every counter is weakly not taken (2'b01). A first prediction therefore reports history 0 and not taken.
- R2: `pred_valid_o` is high in the cycle after a cycle with `pred_req_i` high, and low in the cycle after a cycle with `pred_req_i` low.
- R3: `pred_hist_o` is the history entry selected by the request address. `pred_taken_o` is bit 1 of the counter selected by that history, where 1 means taken.
- R4: An update with outcome taken raises the selected counter by one and stops at 2'b11. An update with outcome not taken lowers it by one and stops at 2'b00. Because of this, one opposite outcome does not flip a strongly biased counter.
- R5: An update shifts the history entry left by one. The actual outcome enters bit 0, and the oldest bit is dropped.
- R6: The counter trained on update is the one indexed by `upd_hist_i`, not the one indexed by the current history of `upd_pc_i`.
- R7: The table index is address bits [IDX_W+1:2]. Address bits [1:0] and the bits above the index have no effect, so aliased addresses share one history.
- R8: If a request and an update arrive in the same cycle, the request reads the history as it was before the update. The prediction output reflects the counter value after the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pred_req_i | input | 1 | Prediction request |
| pred_pc_i | input | PC_W | Branch address to predict |
| pred_valid_o | output | 1 | Prediction result valid |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_hist_o | output | HIST_W | History value used for the prediction |
| upd_valid_i | input | 1 | Resolved branch update |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_hist_i | input | HIST_W | History value returned from prediction time |
| upd_taken_i | input | 1 | Actual outcome, 1 = taken |

## Verification
The hardest case to reach is the one where the returned history differs from the branch's current history entry. In that case training and shifting touch unrelated state. Another hard case is a prediction that sees an update to the counter it reads in the same cycle. The stimulus creates both on purpose: it sends updates whose history value is chosen freely instead of copied from a prediction, and it issues a request and an update to the same address together. A long random phase over a small address range then causes heavy aliasing. A behavioural model checks every cycle of it.

// File: rtl/lhp_pkg.sv
package lhp_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_SNT = 2'b00;
  localparam ctr_t CTR_WNT = 2'b01;
  localparam ctr_t CTR_ST  = 2'b11;

  function automatic ctr_t ctr_next(ctr_t c, logic taken);
    if (taken) return (c == CTR_ST)  ? c : ctr_t'(c + 2'd1);
    else       return (c == CTR_SNT) ? c : ctr_t'(c - 2'd1);
  endfunction
endpackage

// File: rtl/lhp_hist_table.sv
module lhp_hist_table #(
  parameter int IDX_W  = 6,
  parameter int HIST_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [HIST_W-1:0] rd_hist_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_taken_i
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [HIST_W-1:0] hist_q [ENTRIES];
  logic [HIST_W-1:0] shifted;

  assign rd_hist_o = hist_q[rd_idx_i];
  assign shifted   = HIST_W'({hist_q[wr_idx_i], wr_taken_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) hist_q[i] <= '0;
    end else if (wr_en_i) begin
      hist_q[wr_idx_i] <= shifted;
    end
  end

  // newest outcome lands in bit 0
  assert_hist_lsb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> hist_q[$past(wr_idx_i)][0] == $past(wr_taken_i));

  assert_hist_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_hist_o) || $changed(rd_idx_i));
endmodule

// File: rtl/lhp_pattern_table.sv
module lhp_pattern_table
  import lhp_pkg::*;
#(
  parameter int HIST_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HIST_W-1:0] rd_idx_i,
  output logic              rd_msb_o,
  input  logic              upd_en_i,
  input  logic [HIST_W-1:0] upd_idx_i,
  input  logic              upd_taken_i
);
  localparam int ENTRIES = 1 << HIST_W;

  ctr_t ctr_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ctr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   ctr_q[g] <= CTR_WNT;
      else if (upd_en_i && upd_idx_i == HIST_W'(g))  ctr_q[g] <= ctr_next(ctr_q[g], upd_taken_i);
    end
  end

  assign rd_msb_o = ctr_q[rd_idx_i][1];

  assert_ctr_sat_hi_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && upd_taken_i && ctr_q[upd_idx_i] == CTR_ST) |=> ctr_q[$past(upd_idx_i)] == CTR_ST);

  assert_ctr_sat_lo_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !upd_taken_i && ctr_q[upd_idx_i] == CTR_SNT) |=> ctr_q[$past(upd_idx_i)] == CTR_SNT);

  assert_ctr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && upd_taken_i && ctr_q[upd_idx_i] != CTR_ST)
      |=> ctr_q[$past(upd_idx_i)] == ctr_t'($past(ctr_q[upd_idx_i]) + 2'd1));
endmodule

// File: rtl/local_hist_predictor.sv
module local_hist_predictor #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 6,
  parameter int HIST_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pred_req_i,
  input  logic [PC_W-1:0]   pred_pc_i,
  output logic              pred_valid_o,
  output logic              pred_taken_o,
  output logic [HIST_W-1:0] pred_hist_o,
  input  logic              upd_valid_i,
  input  logic [PC_W-1:0]   upd_pc_i,
  input  logic [HIST_W-1:0] upd_hist_i,
  input  logic              upd_taken_i
);
  localparam int PC_LSB = 2;
  localparam int PC_MSB = PC_LSB + IDX_W - 1;

  logic [IDX_W-1:0]  pred_idx, upd_idx;
  logic [HIST_W-1:0] rd_hist, hist_q;
  logic              valid_q, ctr_msb;

  assign pred_idx = pred_pc_i[PC_MSB:PC_LSB];
  assign upd_idx  = upd_pc_i[PC_MSB:PC_LSB];

  lhp_hist_table #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_hist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (pred_idx),
    .rd_hist_o  (rd_hist),
    .wr_en_i    (upd_valid_i),
    .wr_idx_i   (upd_idx),
    .wr_taken_i (upd_taken_i)
  );

  // first lookup registered; second lookup reads from the captured history
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      hist_q  <= '0;
    end else begin
      valid_q <= pred_req_i;
      if (pred_req_i) hist_q <= rd_hist;
    end
  end

  lhp_pattern_table #(.HIST_W(HIST_W)) u_pat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_idx_i    (hist_q),
    .rd_msb_o    (ctr_msb),
    .upd_en_i    (upd_valid_i),
    .upd_idx_i   (upd_hist_i),
    .upd_taken_i (upd_taken_i)
  );

  assign pred_valid_o = valid_q;
  assign pred_taken_o = ctr_msb;
  assign pred_hist_o  = hist_q;

  assert_valid_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_req_i |=> pred_valid_o);

  assert_valid_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_req_i |=> !pred_valid_o);

  assert_hist_capture_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_req_i |=> pred_hist_o == $past(rd_hist));
endmodule

// File: tb/local_hist_predictor_tb.sv
module local_hist_predictor_tb;
  localparam int PC_W = 32, IDX_W = 6, HIST_W = 4;
  localparam int NE = 1 << IDX_W, NC = 1 << HIST_W;

  logic clk_i = 0, rst_ni = 0;
  logic pred_req_i = 0, upd_valid_i = 0, upd_taken_i = 0;
  logic [PC_W-1:0] pred_pc_i = '0, upd_pc_i = '0;
  logic [HIST_W-1:0] upd_hist_i = '0;
  logic pred_valid_o, pred_taken_o;
  logic [HIST_W-1:0] pred_hist_o;

  int checks = 0, failures = 0, cycles = 0;
  string phase = "R1";

  always #10 clk_i = ~clk_i;

  local_hist_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_dut (.*);

  // behavioural reference
  int m_hist [NE];
  int m_ctr  [NC];
  bit exp_valid;
  int exp_hist;

  function automatic int idx_of(logic [PC_W-1:0] pc);
    return int'(pc >> 2) % NE;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (m_hist[i]) m_hist[i] = 0;
      foreach (m_ctr[i])  m_ctr[i]  = 1;
      exp_valid = 0; exp_hist = 0;
    end else begin
      bit v; int h;
      v = pred_req_i;
      h = m_hist[idx_of(pred_pc_i)];
      if (upd_valid_i) begin
        int u;
        u = int'(upd_hist_i);
        if (upd_taken_i) m_ctr[u] = (m_ctr[u] < 3) ? m_ctr[u] + 1 : 3;
        else             m_ctr[u] = (m_ctr[u] > 0) ? m_ctr[u] - 1 : 0;
        m_hist[idx_of(upd_pc_i)] = ((m_hist[idx_of(upd_pc_i)] << 1) | int'(upd_taken_i)) % NC;
      end
      exp_valid = v;
      if (v) exp_hist = h;
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      cycles++;
      check(phase, "model valid", int'(pred_valid_o), int'(exp_valid));
      if (exp_valid) begin
        check(phase, "model hist", int'(pred_hist_o), exp_hist);
        check(phase, "model taken", int'(pred_taken_o), int'(m_ctr[exp_hist] >= 2));
      end
    end
  end

  // called at a negedge
  task automatic do_upd(logic [PC_W-1:0] pc, int h, bit t);
    upd_valid_i = 1; upd_pc_i = pc; upd_hist_i = HIST_W'(h); upd_taken_i = t;
    @(negedge clk_i);
    upd_valid_i = 0;
  endtask

  task automatic expect_pred(logic [PC_W-1:0] pc, bit et, int eh, string tag);
    pred_req_i = 1; pred_pc_i = pc;
    @(negedge clk_i);
    pred_req_i = 0; upd_valid_i = 0;
    check(tag, "valid", int'(pred_valid_o), 1);
    check(tag, "hist", int'(pred_hist_o), eh);
    check(tag, "taken", int'(pred_taken_o), int'(et));
    @(negedge clk_i);
    check("R2", "valid after idle", int'(pred_valid_o), 0);
  endtask

  initial begin : wd
    while (cycles < 100000) @(negedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    check("R2", "valid out of reset", int'(pred_valid_o), 0);
    // R1: reset state
    phase = "R1";
    expect_pred(32'h100, 0, 0, "R1");
    // R5: outcomes 1,0,1,1 into entry 16 -> history 4'b1011
    phase = "R5";
    do_upd(32'h40, 0, 1); do_upd(32'h40, 0, 0);
    do_upd(32'h40, 0, 1); do_upd(32'h40, 0, 1);
    expect_pred(32'h40, 0, 11, "R5");
    // R4: saturation and hysteresis on counter 11
    phase = "R4";
    do_upd(32'h300, 11, 1); do_upd(32'h300, 11, 1); do_upd(32'h300, 11, 1);
    expect_pred(32'h40, 1, 11, "R4");
    do_upd(32'h300, 11, 0);
    expect_pred(32'h40, 1, 11, "R4");
    for (int i = 0; i < 5; i++) do_upd(32'h300, 11, 0);
    do_upd(32'h300, 11, 1);
    expect_pred(32'h40, 0, 11, "R4");
    // R6: train counter 9 while entry 32 holds history 0
    phase = "R6";
    do_upd(32'h80, 9, 1);
    do_upd(32'h80, 9, 1);
    expect_pred(32'h80, 0, 3, "R6");
    do_upd(32'h200, 0, 1); do_upd(32'h200, 0, 0);
    do_upd(32'h200, 0, 0); do_upd(32'h200, 0, 1);
    expect_pred(32'h200, 1, 9, "R6");
    // R7: aliased addresses share entry 16
    phase = "R7";
    expect_pred(32'h140, 0, 11, "R7");
    expect_pred(32'h43, 0, 11, "R7");
    // R8: request and update together on the same branch
    phase = "R8";
    do_upd(32'h300, 11, 1);
    upd_valid_i = 1; upd_pc_i = 32'h40; upd_hist_i = 4'd11; upd_taken_i = 1;
    expect_pred(32'h40, 1, 11, "R8");
    expect_pred(32'h40, 0, 7, "R8");
    // R3: random traffic with heavy aliasing
    phase = "R3";
    for (int i = 0; i < 3000; i++) begin
      pred_req_i  = 1'($urandom);
      pred_pc_i   = PC_W'($urandom & 32'h3ff);
      upd_valid_i = 1'($urandom);
      upd_pc_i    = PC_W'($urandom & 32'h3ff);
      upd_hist_i  = HIST_W'($urandom);
      upd_taken_i = 1'($urandom);
      @(negedge clk_i);
    end
    pred_req_i = 0; upd_valid_i = 0;
    @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule